// File: doc/BRIEF.md
# Dual-Path Host Bridge Register File

This block holds the 64-bit control and status words of a host bridge. Two requesters reach the same words. A scan-style register port presents a byte address whose upper bits select a word directly. A memory-mapped port presents a byte offset that lands ten words further up, so its offset zero selects the base-address word. Both addresses are reduced to one common word index. A single register bank then applies the write semantics of each index.

Some indices are write-only aliases. The fault word has an AND alias and an OR alias. The control word has a set alias and a clear alias. The base-address word accepts writes only from the scan path and is masked on write. The secondary base word is also masked on write. The interrupt status word mirrors an input and cannot be written. The six interrupt vector words are driven out to a separate routing block.

Every transfer is one aligned 64-bit word. Each port has a valid/ready request channel and returns read data one cycle after a read is accepted. The scan port is never back-pressured. The memory port is back-pressured (ready low) in every cycle in which the scan port presents a request, and a waiting memory requester must hold its request stable until it sees ready. One request is served per cycle. Any illegal access produces a one-cycle error pulse.

Top module: `hostbridge_regbank`

## Requirements
- R1: The scan word index is the scan byte address shifted right by 3. The memory word index is the memory byte offset shifted right by 3, plus 10 (0x0A). Memory offset 0 therefore reads the base-address word.
- R2: After reset every word reads zero, with one exception: the base-address word (index 0x0A) reads (BASE_DEFAULT AND 0x0003_FFFF_FFF0_0000) OR 1.
- R3: Index 0x00 is the fault word. A write to 0x00 replaces it. A write to 0x01 ANDs the data into it. A write to 0x02 ORs the data into it.
- R4: Index 0x0E is the control word. A write to 0x0E replaces it. A write to 0x12 ORs the data into it. A write to 0x13 clears the bits that are set in the data.
- R5: A scan write to index 0x0A stores the data ANDed with 0x0003_FFFF_FFF0_0001.
- R6: A memory-path write to index 0x0A leaves the word unchanged and raises the error pulse.
- R7: A write to index 0x0B stores the data ANDed with 0x0003_FFFF_0000_0000.
- R8: A read of index 0x15 returns the stat_i input. A write to 0x15 changes nothing and raises the error pulse.
- R9: Some accesses are unimplemented: any index other than 0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x10, 0x14–0x1B, and a read of the write-only aliases 0x01, 0x02, 0x12 and 0x13. An unimplemented read returns all ones. An unimplemented write has no effect. Both raise the error pulse.
- R10: An access whose byte address has a nonzero value in bits [2:0] is illegal. It has no effect, a read returns all ones, and it raises the error pulse.
- R11: sc_ready_o is always high. mm_ready_o is low whenever sc_valid_i is high. A read accepted in cycle n gives rvalid high, with rdata, on that port in cycle n+1 only.
- R12: Indices 0x06, 0x07, 0x0F, 0x14 and 0x1B are plain read/write words. Indices 0x10 and 0x16–0x1A are plain read/write interrupt vector words. Vector slot k (0x10 for k=0, 0x15+k otherwise) appears on vec_cfg_o[64k+63:64k].
- R13: err_o is high for exactly one cycle, the cycle after an illegal access is accepted, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_valid_i | input | 1 | Scan request valid |
| sc_ready_o | output | 1 | Scan request accepted |
| sc_write_i | input | 1 | Scan request is a write |
| sc_addr_i | input | SC_AW | Scan byte address |
| sc_wdata_i | input | 64 | Scan write data |
| sc_rvalid_o | output | 1 | Scan read data valid |
| sc_rdata_o | output | 64 | Scan read data |
| mm_valid_i | input | 1 | Memory request valid |
| mm_ready_o | output | 1 | Memory request accepted |
| mm_write_i | input | 1 | Memory request is a write |
| mm_addr_i | input | MM_AW | Memory byte offset |
| mm_wdata_i | input | 64 | Memory write data |
| mm_rvalid_o | output | 1 | Memory read data valid |
| mm_rdata_o | output | 64 | Memory read data |
| stat_i | input | 64 | Live interrupt status word |
| vec_cfg_o | output | 6*64 | Interrupt vector words to the routing block |
| err_o | output | 1 | One-cycle illegal-access pulse |

## Verification
The bench builds the block with 8-bit addresses on both ports.

- With this width the scan port covers indices 0x00–0x1F.
- The memory port covers 0x0A–0x29, so the bench can reach an index beyond the register set (0x20) from the memory side.
- BASE_DEFAULT is set to all ones except bit 0. This makes the reset masking of the base word, and its forced enable bit, visible at the port.

// File: rtl/hbrf_pkg.sv
package hbrf_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned NUM_VEC = 6;
  localparam int unsigned MEM_OFFSET = 10;

  localparam int IX_FAULT     = 'h00;
  localparam int IX_FAULT_AND = 'h01;
  localparam int IX_FAULT_OR  = 'h02;
  localparam int IX_ACT0      = 'h06;
  localparam int IX_ACT1      = 'h07;
  localparam int IX_BASE      = 'h0A;
  localparam int IX_BASE2     = 'h0B;
  localparam int IX_CTRL      = 'h0E;
  localparam int IX_EMASK     = 'h0F;
  localparam int IX_VEC0      = 'h10;
  localparam int IX_CTRL_SET  = 'h12;
  localparam int IX_CTRL_CLR  = 'h13;
  localparam int IX_DMAHI     = 'h14;
  localparam int IX_STAT      = 'h15;
  localparam int IX_VEC1      = 'h16;
  localparam int IX_SRCCMP    = 'h1B;

  localparam logic [WORD_W-1:0] BASE_MASK  = 64'h0003_FFFF_FFF0_0000;
  localparam logic [WORD_W-1:0] BASE_EN    = 64'h0000_0000_0000_0001;
  localparam logic [WORD_W-1:0] BASE2_MASK = 64'h0003_FFFF_0000_0000;

  typedef enum logic [1:0] {SRC_NONE, SRC_SCAN, SRC_MEM} src_e;

  function automatic int vec_index(input int k);
    return (k == 0) ? IX_VEC0 : IX_VEC1 + k - 1;
  endfunction
endpackage

// File: rtl/hbrf_decode.sv
module hbrf_decode #(
  parameter int unsigned AW     = 8,
  parameter int unsigned IW     = 6,
  parameter int unsigned OFFSET = 0
) (
  input  logic [AW-1:0] addr_i,
  output logic [IW-1:0] idx_o,
  output logic          misaligned_o
);
  assign idx_o        = IW'(addr_i[AW-1:3]) + IW'(OFFSET);
  assign misaligned_o = |addr_i[2:0];
endmodule

// File: rtl/hbrf_arbiter.sv
module hbrf_arbiter
  import hbrf_pkg::*;
#(
  parameter int unsigned IW = 6
) (
  input  logic              sc_valid_i,
  input  logic              sc_write_i,
  input  logic [IW-1:0]     sc_idx_i,
  input  logic              sc_mis_i,
  input  logic [WORD_W-1:0] sc_wdata_i,
  input  logic              mm_valid_i,
  input  logic              mm_write_i,
  input  logic [IW-1:0]     mm_idx_i,
  input  logic              mm_mis_i,
  input  logic [WORD_W-1:0] mm_wdata_i,
  output logic              sc_ready_o,
  output logic              mm_ready_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [IW-1:0]     req_idx_o,
  output logic              req_mis_o,
  output logic [WORD_W-1:0] req_wdata_o,
  output src_e              req_src_o
);
  assign sc_ready_o = 1'b1;
  assign mm_ready_o = !sc_valid_i;

  always_comb begin
    req_valid_o = 1'b0;
    req_write_o = 1'b0;
    req_idx_o   = '0;
    req_mis_o   = 1'b0;
    req_wdata_o = '0;
    req_src_o   = SRC_NONE;
    if (sc_valid_i) begin
      req_valid_o = 1'b1;
      req_write_o = sc_write_i;
      req_idx_o   = sc_idx_i;
      req_mis_o   = sc_mis_i;
      req_wdata_o = sc_wdata_i;
      req_src_o   = SRC_SCAN;
    end else if (mm_valid_i) begin
      req_valid_o = 1'b1;
      req_write_o = mm_write_i;
      req_idx_o   = mm_idx_i;
      req_mis_o   = mm_mis_i;
      req_wdata_o = mm_wdata_i;
      req_src_o   = SRC_MEM;
    end
  end
endmodule

// File: rtl/hbrf_regs.sv
module hbrf_regs
  import hbrf_pkg::*;
#(
  parameter int unsigned       IW           = 6,
  parameter logic [WORD_W-1:0] BASE_DEFAULT = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic [IW-1:0]             req_idx_i,
  input  logic                      req_mis_i,
  input  logic [WORD_W-1:0]         req_wdata_i,
  input  src_e                      req_src_i,
  input  logic [WORD_W-1:0]         stat_i,
  output logic [WORD_W-1:0]         rdata_o,
  output logic                      err_o,
  output logic [NUM_VEC*WORD_W-1:0] vec_o
);
  localparam int unsigned VSEL_W = $clog2(NUM_VEC);

  logic [WORD_W-1:0] fault_q, act0_q, act1_q, base_q, base2_q, ctrl_q, emask_q, dmahi_q, srccmp_q;
  logic [WORD_W-1:0] fault_d, act0_d, act1_d, base_d, base2_d, ctrl_d, emask_d, dmahi_d, srccmp_d;
  logic [WORD_W-1:0] vec_q [NUM_VEC];
  logic [WORD_W-1:0] vec_d [NUM_VEC];
  logic [WORD_W-1:0] rd;
  logic              illegal, vhit;
  logic [VSEL_W-1:0] vsel;
  int                idx;

  assign idx = int'(req_idx_i);

  always_comb begin
    vhit = 1'b0;
    vsel = '0;
    for (int k = 0; k < int'(NUM_VEC); k++) begin
      if (idx == vec_index(k)) begin
        vhit = 1'b1;
        vsel = VSEL_W'(k);
      end
    end
  end

  always_comb begin
    fault_d = fault_q; act0_d = act0_q; act1_d = act1_q;
    base_d  = base_q;  base2_d = base2_q; ctrl_d = ctrl_q;
    emask_d = emask_q; dmahi_d = dmahi_q; srccmp_d = srccmp_q;
    vec_d   = vec_q;
    rd      = '1;
    illegal = 1'b0;
    if (req_valid_i) begin
      if (req_mis_i) begin
        illegal = 1'b1;
      end else if (req_write_i) begin
        if (vhit) vec_d[vsel] = req_wdata_i;
        else begin
          case (idx)
            IX_FAULT:     fault_d  = req_wdata_i;
            IX_FAULT_AND: fault_d  = fault_q & req_wdata_i;
            IX_FAULT_OR:  fault_d  = fault_q | req_wdata_i;
            IX_ACT0:      act0_d   = req_wdata_i;
            IX_ACT1:      act1_d   = req_wdata_i;
            IX_BASE: begin
              if (req_src_i == SRC_SCAN) base_d = req_wdata_i & (BASE_MASK | BASE_EN);
              else illegal = 1'b1;
            end
            IX_BASE2:     base2_d  = req_wdata_i & BASE2_MASK;
            IX_CTRL:      ctrl_d   = req_wdata_i;
            IX_CTRL_SET:  ctrl_d   = ctrl_q | req_wdata_i;
            IX_CTRL_CLR:  ctrl_d   = ctrl_q & ~req_wdata_i;
            IX_EMASK:     emask_d  = req_wdata_i;
            IX_DMAHI:     dmahi_d  = req_wdata_i;
            IX_SRCCMP:    srccmp_d = req_wdata_i;
            default:      illegal  = 1'b1;
          endcase
        end
      end else begin
        if (vhit) rd = vec_q[vsel];
        else begin
          case (idx)
            IX_FAULT:  rd = fault_q;
            IX_ACT0:   rd = act0_q;
            IX_ACT1:   rd = act1_q;
            IX_BASE:   rd = base_q;
            IX_BASE2:  rd = base2_q;
            IX_CTRL:   rd = ctrl_q;
            IX_EMASK:  rd = emask_q;
            IX_DMAHI:  rd = dmahi_q;
            IX_STAT:   rd = stat_i;
            IX_SRCCMP: rd = srccmp_q;
            default:   illegal = 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0; act0_q <= '0; act1_q <= '0;
      base_q  <= (BASE_DEFAULT & BASE_MASK) | BASE_EN;
      base2_q <= '0; ctrl_q <= '0; emask_q <= '0; dmahi_q <= '0; srccmp_q <= '0;
      for (int k = 0; k < int'(NUM_VEC); k++) vec_q[k] <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      fault_q <= fault_d; act0_q <= act0_d; act1_q <= act1_d;
      base_q  <= base_d;  base2_q <= base2_d; ctrl_q <= ctrl_d;
      emask_q <= emask_d; dmahi_q <= dmahi_d; srccmp_q <= srccmp_d;
      vec_q   <= vec_d;
      if (req_valid_i && !req_write_i) rdata_o <= rd;
      err_o <= illegal;
    end
  end

  for (genvar g = 0; g < int'(NUM_VEC); g++) begin : g_vec_out
    assign vec_o[g*WORD_W +: WORD_W] = vec_q[g];
  end
endmodule

// File: rtl/hostbridge_regbank.sv
module hostbridge_regbank
  import hbrf_pkg::*;
#(
  parameter int unsigned       SC_AW        = 8,
  parameter int unsigned       MM_AW        = 8,
  parameter logic [WORD_W-1:0] BASE_DEFAULT = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sc_valid_i,
  output logic                      sc_ready_o,
  input  logic                      sc_write_i,
  input  logic [SC_AW-1:0]          sc_addr_i,
  input  logic [WORD_W-1:0]         sc_wdata_i,
  output logic                      sc_rvalid_o,
  output logic [WORD_W-1:0]         sc_rdata_o,
  input  logic                      mm_valid_i,
  output logic                      mm_ready_o,
  input  logic                      mm_write_i,
  input  logic [MM_AW-1:0]          mm_addr_i,
  input  logic [WORD_W-1:0]         mm_wdata_i,
  output logic                      mm_rvalid_o,
  output logic [WORD_W-1:0]         mm_rdata_o,
  input  logic [WORD_W-1:0]         stat_i,
  output logic [NUM_VEC*WORD_W-1:0] vec_cfg_o,
  output logic                      err_o
);
  // Common index is one bit wider than the widest word address so that the
  // memory-side offset cannot wrap onto a low index (needs MM_AW >= 7).
  localparam int unsigned IW = ((SC_AW > MM_AW) ? SC_AW : MM_AW) - 2;

  logic [IW-1:0]     sc_idx, mm_idx, req_idx;
  logic              sc_mis, mm_mis, req_mis, req_valid, req_write;
  logic [WORD_W-1:0] req_wdata, rdata;
  src_e              req_src;
  logic              sc_rv_q, mm_rv_q;

  hbrf_decode #(.AW(SC_AW), .IW(IW), .OFFSET(0)) u_sc_dec (
    .addr_i(sc_addr_i), .idx_o(sc_idx), .misaligned_o(sc_mis));

  hbrf_decode #(.AW(MM_AW), .IW(IW), .OFFSET(MEM_OFFSET)) u_mm_dec (
    .addr_i(mm_addr_i), .idx_o(mm_idx), .misaligned_o(mm_mis));

  hbrf_arbiter #(.IW(IW)) u_arb (
    .sc_valid_i(sc_valid_i), .sc_write_i(sc_write_i), .sc_idx_i(sc_idx),
    .sc_mis_i(sc_mis), .sc_wdata_i(sc_wdata_i),
    .mm_valid_i(mm_valid_i), .mm_write_i(mm_write_i), .mm_idx_i(mm_idx),
    .mm_mis_i(mm_mis), .mm_wdata_i(mm_wdata_i),
    .sc_ready_o(sc_ready_o), .mm_ready_o(mm_ready_o),
    .req_valid_o(req_valid), .req_write_o(req_write), .req_idx_o(req_idx),
    .req_mis_o(req_mis), .req_wdata_o(req_wdata), .req_src_o(req_src));

  hbrf_regs #(.IW(IW), .BASE_DEFAULT(BASE_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_idx_i(req_idx),
    .req_mis_i(req_mis), .req_wdata_i(req_wdata), .req_src_i(req_src),
    .stat_i(stat_i), .rdata_o(rdata), .err_o(err_o), .vec_o(vec_cfg_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_rv_q <= 1'b0;
      mm_rv_q <= 1'b0;
    end else begin
      sc_rv_q <= sc_valid_i && sc_ready_o && !sc_write_i;
      mm_rv_q <= mm_valid_i && mm_ready_o && !mm_write_i;
    end
  end

  assign sc_rvalid_o = sc_rv_q;
  assign mm_rvalid_o = mm_rv_q;
  assign sc_rdata_o  = rdata;
  assign mm_rdata_o  = rdata;
endmodule

// File: rtl/hostbridge_regbank_chk.sv
module hostbridge_regbank_chk #(
  parameter int unsigned SC_AW = 8,
  parameter int unsigned MM_AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sc_valid_i,
  input logic             sc_ready_o,
  input logic             sc_write_i,
  input logic [SC_AW-1:0] sc_addr_i,
  input logic             sc_rvalid_o,
  input logic             mm_valid_i,
  input logic             mm_ready_o,
  input logic             mm_write_i,
  input logic [MM_AW-1:0] mm_addr_i,
  input logic             mm_rvalid_o,
  input logic             err_o
);
  logic sc_acc, mm_acc;
  assign sc_acc = sc_valid_i && sc_ready_o;
  assign mm_acc = mm_valid_i && mm_ready_o;

  AST_SCAN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) sc_valid_i |-> !mm_ready_o); // R11
  AST_SC_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (sc_acc && !sc_write_i) |=> sc_rvalid_o); // R11
  AST_MM_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (mm_acc && !mm_write_i) |=> mm_rvalid_o); // R11
  AST_SC_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) sc_rvalid_o |-> $past(sc_acc && !sc_write_i)); // R11
  AST_MM_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) mm_rvalid_o |-> $past(mm_acc && !mm_write_i)); // R11
  AST_MEM_BASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (mm_acc && mm_write_i && mm_addr_i == '0) |=> err_o); // R6
  AST_STAT_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (sc_acc && sc_write_i && sc_addr_i == SC_AW'(8'hA8)) |=> err_o); // R8
  AST_MISALIGNED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (sc_acc && sc_addr_i[2:0] != 3'b000) |=> err_o); // R10
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) err_o |-> $past(sc_acc || mm_acc)); // R13
endmodule

bind hostbridge_regbank hostbridge_regbank_chk #(.SC_AW(SC_AW), .MM_AW(MM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sc_valid_i(sc_valid_i), .sc_ready_o(sc_ready_o), .sc_write_i(sc_write_i),
  .sc_addr_i(sc_addr_i), .sc_rvalid_o(sc_rvalid_o),
  .mm_valid_i(mm_valid_i), .mm_ready_o(mm_ready_o), .mm_write_i(mm_write_i),
  .mm_addr_i(mm_addr_i), .mm_rvalid_o(mm_rvalid_o), .err_o(err_o));

// File: tb/hostbridge_regbank_test.sv
module hostbridge_regbank_test;
  localparam logic [63:0] DEF = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_valid = 1'b0, sc_write = 1'b0, mm_valid = 1'b0, mm_write = 1'b0;
  logic [7:0] sc_addr = '0, mm_addr = '0;
  logic [63:0] sc_wdata = '0, mm_wdata = '0, stat = '0;
  logic sc_ready, mm_ready, sc_rvalid, mm_rvalid, err;
  logic [63:0] sc_rdata, mm_rdata;
  logic [383:0] vec_cfg;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hostbridge_regbank #(.SC_AW(8), .MM_AW(8), .BASE_DEFAULT(DEF)) uut (
    .clk(clk), .rst_n(rst_n),
    .sc_valid_i(sc_valid), .sc_ready_o(sc_ready), .sc_write_i(sc_write),
    .sc_addr_i(sc_addr), .sc_wdata_i(sc_wdata), .sc_rvalid_o(sc_rvalid), .sc_rdata_o(sc_rdata),
    .mm_valid_i(mm_valid), .mm_ready_o(mm_ready), .mm_write_i(mm_write),
    .mm_addr_i(mm_addr), .mm_wdata_i(mm_wdata), .mm_rvalid_o(mm_rvalid), .mm_rdata_o(mm_rdata),
    .stat_i(stat), .vec_cfg_o(vec_cfg), .err_o(err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sa(input int idx);
    return 8'(idx * 8);
  endfunction

  function automatic logic [7:0] ma(input int idx);
    return 8'((idx - 10) * 8);
  endfunction

  task automatic sc_op(input logic w, input logic [7:0] a, input logic [63:0] d,
                       output logic [63:0] rd, output logic er);
    @(negedge clk);
    sc_valid = 1'b1; sc_write = w; sc_addr = a; sc_wdata = d;
    @(negedge clk);
    sc_valid = 1'b0; sc_write = 1'b0;
    rd = sc_rdata; er = err;
  endtask

  task automatic mm_op(input logic w, input logic [7:0] a, input logic [63:0] d,
                       output logic [63:0] rd, output logic er);
    @(negedge clk);
    mm_valid = 1'b1; mm_write = w; mm_addr = a; mm_wdata = d;
    @(negedge clk);
    mm_valid = 1'b0; mm_write = 1'b0;
    rd = mm_rdata; er = err;
  endtask

  task automatic sc_wr(input string req, input int idx, input logic [63:0] d, input logic exp_err);
    logic [63:0] rd; logic er;
    sc_op(1'b1, sa(idx), d, rd, er);
    check({req, " err after write"}, 64'(er), 64'(exp_err));
  endtask

  task automatic sc_rd(input string req, input int idx, input logic [63:0] exp, input logic exp_err);
    logic [63:0] rd; logic er;
    sc_op(1'b0, sa(idx), '0, rd, er);
    check(req, rd, exp);
    check({req, " err after read"}, 64'(er), 64'(exp_err));
  endtask

  task automatic t_reset;
    logic [63:0] rd; logic er;
    check("R13 err idle after reset", 64'(err), 64'h0);
    sc_rd("R2 fault reset", 'h00, 64'h0, 1'b0);
    sc_rd("R2 control reset", 'h0E, 64'h0, 1'b0);
    sc_rd("R2 base reset", 'h0A, 64'h0003_FFFF_FFF0_0001, 1'b0);
    sc_rd("R2 vector reset", 'h16, 64'h0, 1'b0);
    check("R2 vec_cfg reset", vec_cfg[63:0] | vec_cfg[383:320], 64'h0);
    mm_op(1'b0, 8'h00, '0, rd, er);
    check("R1 memory offset 0 is base", rd, 64'h0003_FFFF_FFF0_0001);
  endtask

  task automatic t_index;
    logic [63:0] rd; logic er;
    sc_wr("R1 scan ctrl", 'h0E, 64'h1234_5678_9ABC_DEF0, 1'b0);
    mm_op(1'b0, ma('h0E), '0, rd, er);
    check("R1 memory reads ctrl", rd, 64'h1234_5678_9ABC_DEF0);
    mm_op(1'b1, ma('h14), 64'hCAFE_0000_0000_BEEF, rd, er);
    sc_rd("R1 scan reads memory-written word", 'h14, 64'hCAFE_0000_0000_BEEF, 1'b0);
  endtask

  task automatic t_fault;
    sc_wr("R3 fault write", 'h00, 64'hF0F0_F0F0_00FF_00FF, 1'b0);
    sc_rd("R3 fault replace", 'h00, 64'hF0F0_F0F0_00FF_00FF, 1'b0);
    sc_wr("R3 fault and", 'h01, 64'hFF00_FF00_0F0F_0F0F, 1'b0);
    sc_rd("R3 fault after and", 'h00, 64'hF000_F000_000F_000F, 1'b0);
    sc_wr("R3 fault or", 'h02, 64'h0000_0001_8000_0000, 1'b0);
    sc_rd("R3 fault after or", 'h00, 64'hF000_F001_800F_000F, 1'b0);
  endtask

  task automatic t_ctrl;
    logic [63:0] rd; logic er;
    sc_wr("R4 ctrl write", 'h0E, 64'h0000_00FF_0000_00F0, 1'b0);
    sc_wr("R4 ctrl set", 'h12, 64'h8000_0000_0000_000F, 1'b0);
    sc_rd("R4 ctrl after set", 'h0E, 64'h8000_00FF_0000_00FF, 1'b0);
    sc_wr("R4 ctrl clear", 'h13, 64'h0000_000F_0000_0081, 1'b0);
    sc_rd("R4 ctrl after clear", 'h0E, 64'h8000_00F0_0000_007E, 1'b0);
    mm_op(1'b1, ma('h12), 64'h0100_0000_0000_0000, rd, er);
    sc_rd("R4 ctrl set via memory", 'h0E, 64'h8100_00F0_0000_007E, 1'b0);
  endtask

  task automatic t_base;
    logic [63:0] rd; logic er;
    sc_wr("R5 base scan write", 'h0A, ONES, 1'b0);
    sc_rd("R5 base masked", 'h0A, 64'h0003_FFFF_FFF0_0001, 1'b0);
    sc_wr("R5 base scan write 2", 'h0A, 64'h0001_2345_6789_ABCE, 1'b0);
    sc_rd("R5 base masked 2", 'h0A, 64'h0001_2345_6780_0000, 1'b0);
    mm_op(1'b1, 8'h00, ONES, rd, er);
    check("R6 memory base write flagged", 64'(er), 64'h1);
    sc_rd("R6 base unchanged", 'h0A, 64'h0001_2345_6780_0000, 1'b0);
    sc_wr("R7 base2 write", 'h0B, ONES, 1'b0);
    sc_rd("R7 base2 masked", 'h0B, 64'h0003_FFFF_0000_0000, 1'b0);
  endtask

  task automatic t_stat;
    stat = 64'h0000_0013_0000_0000;
    sc_rd("R8 status mirrors input", 'h15, 64'h0000_0013_0000_0000, 1'b0);
    sc_wr("R8 status write flagged", 'h15, 64'hDEAD_BEEF_DEAD_BEEF, 1'b1);
    sc_rd("R8 status unchanged", 'h15, 64'h0000_0013_0000_0000, 1'b0);
    stat = 64'h5;
    sc_rd("R8 status follows input", 'h15, 64'h5, 1'b0);
  endtask

  task automatic t_unimpl;
    logic [63:0] rd; logic er;
    sc_rd("R9 unimplemented read", 'h03, ONES, 1'b1);
    sc_wr("R9 unimplemented write", 'h03, 64'h0, 1'b1);
    sc_rd("R9 still ones after write", 'h03, ONES, 1'b1);
    sc_rd("R9 fault untouched", 'h00, 64'hF000_F001_800F_000F, 1'b0);
    sc_rd("R9 alias read", 'h01, ONES, 1'b1);
    sc_rd("R9 set alias read", 'h12, ONES, 1'b1);
    mm_op(1'b0, ma('h20), '0, rd, er);
    check("R9 memory beyond bank", rd, ONES);
    check("R9 memory beyond bank err", 64'(er), 64'h1);
  endtask

  task automatic t_misaligned;
    logic [63:0] rd; logic er;
    sc_op(1'b1, 8'h04, 64'h0, rd, er);
    check("R10 misaligned write err", 64'(er), 64'h1);
    sc_rd("R10 fault unchanged", 'h00, 64'hF000_F001_800F_000F, 1'b0);
    sc_op(1'b0, sa('h0E) + 8'h2, '0, rd, er);
    check("R10 misaligned read ones", rd, ONES);
    check("R10 misaligned read err", 64'(er), 64'h1);
  endtask

  task automatic t_plain;
    for (int k = 0; k < 6; k++) begin
      automatic int ix = (k == 0) ? 'h10 : 'h15 + k;
      sc_wr("R12 vector write", ix, 64'hA5A5_0000_0000_0000 + 64'(k), 1'b0);
    end
    for (int k = 0; k < 6; k++) begin
      automatic int ix = (k == 0) ? 'h10 : 'h15 + k;
      sc_rd("R12 vector readback", ix, 64'hA5A5_0000_0000_0000 + 64'(k), 1'b0);
      check("R12 vec_cfg slot", vec_cfg[k*64 +: 64], 64'hA5A5_0000_0000_0000 + 64'(k));
    end
    sc_wr("R12 act1", 'h07, 64'h7777, 1'b0);
    sc_wr("R12 srccmp", 'h1B, 64'h1B1B, 1'b0);
    sc_rd("R12 act1 readback", 'h07, 64'h7777, 1'b0);
    sc_rd("R12 srccmp readback", 'h1B, 64'h1B1B, 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    sc_valid = 1'b1; sc_write = 1'b0; sc_addr = sa('h07);
    mm_valid = 1'b1; mm_write = 1'b0; mm_addr = ma('h1B);
    #1;
    check("R11 scan ready", 64'(sc_ready), 64'h1);
    check("R11 memory held off", 64'(mm_ready), 64'h0);
    @(negedge clk);
    check("R11 scan rvalid", 64'(sc_rvalid), 64'h1);
    check("R11 no memory rvalid", 64'(mm_rvalid), 64'h0);
    check("R11 scan rdata", sc_rdata, 64'h7777);
    sc_valid = 1'b0;
    #1;
    check("R11 memory ready after scan", 64'(mm_ready), 64'h1);
    @(negedge clk);
    mm_valid = 1'b0;
    check("R11 memory rvalid", 64'(mm_rvalid), 64'h1);
    check("R11 scan rvalid dropped", 64'(sc_rvalid), 64'h0);
    check("R11 memory rdata", mm_rdata, 64'h1B1B);
    @(negedge clk);
    check("R11 memory rvalid one cycle", 64'(mm_rvalid), 64'h0);
  endtask

  task automatic t_errpulse;
    logic [63:0] rd; logic er;
    sc_op(1'b0, sa('h04), '0, rd, er);
    check("R13 err pulse high", 64'(er), 64'h1);
    @(negedge clk);
    check("R13 err pulse one cycle", 64'(err), 64'h0);
    sc_wr("R13 legal write no err", 'h0F, 64'h1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_fault();
    t_ctrl();
    t_base();
    t_stat();
    t_unimpl();
    t_misaligned();
    t_plain();
    t_priority();
    t_errpulse();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule